// File: doc/BRIEF.md
# Bitmap Priority Scheduler Assist

This block sits beside a processor that runs a real-time kernel. It takes over the bookkeeping the kernel does on every tick and every interrupt return. It keeps a ready map of up to 64 task priorities in two levels: eight row registers of eight bits each, plus an eight-bit group register that marks which rows hold any ready task. A combinational lowest-set-bit search over the group register, and then over the selected row, gives the most urgent ready task. A smaller number means a more urgent task.

The block also counts interrupt nesting and scheduler-lock nesting. When the last nested interrupt returns, the lock depth is zero, and the most urgent ready task is not the one now running, the block raises a one-cycle switch request. In the same edge it loads the new current priority and increments a 32-bit switch counter. Software can also load the current priority directly, for example when the kernel switches tasks itself.

Top module: `prio_sched_assist`

## Requirements
- R1: After reset no task is ready, `hi_vld_o` is 0, `sw_req_o` is 0, `sw_cnt_o` is 0 and `cur_prio_o` is 63, the least urgent priority.
- R2: A priority p is bits [5:3] row and bits [2:0] column. A set command marks column p[2:0] of row p[5:3] and marks group bit p[5:3]. `hi_prio_o` = 8*y + x, where y is the lowest marked group bit and x is the lowest marked bit of row y, so the numerically smallest ready priority wins.
- R3: A clear command unmarks only its own task. Other tasks in the same row stay found, and the group bit drops only when its row becomes empty. A set and a clear of the same priority in one cycle leave that task not ready.
- R4: The lookup is combinational from the ready map, so `hi_prio_o` and `hi_vld_o` reflect an update in the cycle right after the clock edge that writes it.
- R5: With no task ready, `hi_vld_o` is 0 and no switch is requested.
- R6: Each interrupt entry raises the interrupt depth and each exit lowers it. An exit at depth zero is ignored, and an entry and exit in the same cycle cancel. A switch decision is taken only on an exit that brings the depth from 1 to 0.
- R7: Lock raises the lock depth and unlock lowers it, saturating at zero. While the depth is non-zero, no switch is requested.
- R8: A switch is requested only when the found priority differs from the current priority.
- R9: A granted switch pulses `sw_req_o` for one cycle, starting with the edge that samples the exit strobe. The same edge loads `cur_prio_o` with the found priority and adds 1 to `sw_cnt_o`.
- R10: `cur_load_i` loads `cur_prio_i` into the current priority at the next edge when no switch is granted in that cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| set_vld_i | input | 1 | Mark a task ready |
| set_prio_i | input | 6 | Priority to mark |
| clr_vld_i | input | 1 | Mark a task not ready |
| clr_prio_i | input | 6 | Priority to unmark |
| irq_enter_i | input | 1 | Interrupt entry strobe |
| irq_exit_i | input | 1 | Interrupt exit strobe |
| lock_i | input | 1 | Scheduler lock strobe |
| unlock_i | input | 1 | Scheduler unlock strobe |
| cur_load_i | input | 1 | Load the current priority |
| cur_prio_i | input | 6 | Value for the current priority |
| hi_vld_o | output | 1 | At least one task is ready |
| hi_prio_o | output | 6 | Most urgent ready priority |
| cur_prio_o | output | 6 | Priority of the running task |
| sw_req_o | output | 1 | One-cycle switch request |
| sw_cnt_o | output | 32 | Number of switches granted |

## Verification
The assertions assume that every strobe is a clean single-cycle pulse sampled at the clock. They assume that the depth counters never reach their ceiling, because a saturated entry or lock would no longer match the stack of strobes. The stimulus raises interrupt and lock depth only a few levels, and it drives one command per kind per cycle. The ready-map sweep marks every ordered pair of priorities, including a task paired with itself, and clears them one at a time.

// File: rtl/psa_pkg.sv
package psa_pkg;
  localparam int unsigned DEF_GRP_BITS = 3;
  localparam int unsigned DEF_COL_BITS = 3;
  localparam int unsigned DEF_NEST_W   = 4;
  localparam int unsigned DEF_CNT_W    = 32;
endpackage

// File: rtl/psa_lsb_find.sv
module psa_lsb_find #(
  parameter int unsigned W  = 8,
  localparam int unsigned IW = $clog2(W)
) (
  input  logic [W-1:0]  vec_i,
  output logic [IW-1:0] idx_o,
  output logic          found_o
);
  always_comb begin
    idx_o   = '0;
    found_o = 1'b0;
    for (int i = W - 1; i >= 0; i--) begin
      if (vec_i[i]) begin
        idx_o   = IW'(i);
        found_o = 1'b1;
      end
    end
  end

  always_comb begin
    if (found_o) AST_LSB_HIT: assert (vec_i[idx_o]); // R2
  end
endmodule

// File: rtl/psa_ready_map.sv
module psa_ready_map #(
  parameter int unsigned GRP_BITS = 3,
  parameter int unsigned COL_BITS = 3,
  localparam int unsigned PRIO_W  = GRP_BITS + COL_BITS,
  localparam int unsigned N_ROWS  = 1 << GRP_BITS,
  localparam int unsigned ROW_W   = 1 << COL_BITS
) (
  input  logic                     clk_i,
  input  logic                     rst_ni,
  input  logic                     set_vld_i,
  input  logic [PRIO_W-1:0]        set_prio_i,
  input  logic                     clr_vld_i,
  input  logic [PRIO_W-1:0]        clr_prio_i,
  output logic [N_ROWS*ROW_W-1:0]  rows_o,
  output logic [N_ROWS-1:0]        group_o
);
  logic [ROW_W-1:0] set_bit, clr_bit;
  assign set_bit = ROW_W'(1) << set_prio_i[COL_BITS-1:0];
  assign clr_bit = ROW_W'(1) << clr_prio_i[COL_BITS-1:0];

  for (genvar r = 0; r < N_ROWS; r++) begin : g_row
    logic [ROW_W-1:0] row_q, row_d, set_m, clr_m;
    logic             grp_q;
    assign set_m = (set_vld_i && set_prio_i[PRIO_W-1:COL_BITS] == GRP_BITS'(r)) ? set_bit : '0;
    assign clr_m = (clr_vld_i && clr_prio_i[PRIO_W-1:COL_BITS] == GRP_BITS'(r)) ? clr_bit : '0;
    // clear wins over a same-cycle set
    assign row_d = (row_q | set_m) & ~clr_m;

    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) begin
        row_q <= '0;
        grp_q <= 1'b0;
      end else begin
        row_q <= row_d;
        grp_q <= |row_d;
      end
    end

    assign rows_o[r*ROW_W +: ROW_W] = row_q;
    assign group_o[r]               = grp_q;
  end

  AST_SET_TAKES: assert property (@(posedge clk_i) disable iff (!rst_ni)
    set_vld_i && !(clr_vld_i && clr_prio_i == set_prio_i) |=> rows_o[$past(set_prio_i)]); // R2
  AST_CLR_TAKES: assert property (@(posedge clk_i) disable iff (!rst_ni)
    clr_vld_i |=> !rows_o[$past(clr_prio_i)]); // R3
endmodule

// File: rtl/psa_nest_ctrl.sv
module psa_nest_ctrl #(
  parameter int unsigned NEST_W = 4
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic irq_enter_i,
  input  logic irq_exit_i,
  input  logic lock_i,
  input  logic unlock_i,
  output logic last_exit_o,
  output logic unlocked_o
);
  localparam logic [NEST_W-1:0] MAX = '1;

  logic [NEST_W-1:0] irq_q, lock_q;
  logic irq_up, irq_dn, lk_up, lk_dn;

  assign irq_up = irq_enter_i && !irq_exit_i && irq_q != MAX;
  assign irq_dn = irq_exit_i && !irq_enter_i && irq_q != '0;
  assign lk_up  = lock_i && !unlock_i && lock_q != MAX;
  assign lk_dn  = unlock_i && !lock_i && lock_q != '0;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      irq_q  <= '0;
      lock_q <= '0;
    end else begin
      if (irq_up)      irq_q <= irq_q + NEST_W'(1);
      else if (irq_dn) irq_q <= irq_q - NEST_W'(1);
      if (lk_up)       lock_q <= lock_q + NEST_W'(1);
      else if (lk_dn)  lock_q <= lock_q - NEST_W'(1);
    end
  end

  assign last_exit_o = irq_dn && irq_q == NEST_W'(1);
  assign unlocked_o  = lock_q == '0;

  AST_IRQ_FLOOR: assert property (@(posedge clk_i) disable iff (!rst_ni)
    irq_exit_i && !irq_enter_i && irq_q == '0 |=> irq_q == '0); // R6
  AST_LOCK_FLOOR: assert property (@(posedge clk_i) disable iff (!rst_ni)
    unlock_i && !lock_i && lock_q == '0 |=> lock_q == '0); // R7
  AST_LOCK_STEP: assert property (@(posedge clk_i) disable iff (!rst_ni)
    lock_i && !unlock_i && lock_q != MAX |=> lock_q == $past(lock_q) + NEST_W'(1)); // R7
endmodule

// File: rtl/prio_sched_assist.sv
module prio_sched_assist
  import psa_pkg::*;
#(
  parameter int unsigned GRP_BITS = DEF_GRP_BITS,
  parameter int unsigned COL_BITS = DEF_COL_BITS,
  parameter int unsigned NEST_W   = DEF_NEST_W,
  parameter int unsigned CNT_W    = DEF_CNT_W,
  localparam int unsigned PRIO_W  = GRP_BITS + COL_BITS,
  localparam int unsigned N_ROWS  = 1 << GRP_BITS,
  localparam int unsigned ROW_W   = 1 << COL_BITS
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              set_vld_i,
  input  logic [PRIO_W-1:0] set_prio_i,
  input  logic              clr_vld_i,
  input  logic [PRIO_W-1:0] clr_prio_i,
  input  logic              irq_enter_i,
  input  logic              irq_exit_i,
  input  logic              lock_i,
  input  logic              unlock_i,
  input  logic              cur_load_i,
  input  logic [PRIO_W-1:0] cur_prio_i,
  output logic              hi_vld_o,
  output logic [PRIO_W-1:0] hi_prio_o,
  output logic [PRIO_W-1:0] cur_prio_o,
  output logic              sw_req_o,
  output logic [CNT_W-1:0]  sw_cnt_o
);
  logic [N_ROWS*ROW_W-1:0] rows;
  logic [N_ROWS-1:0]       group;
  logic [GRP_BITS-1:0]     grp_idx;
  logic [COL_BITS-1:0]     col_idx;
  logic [ROW_W-1:0]        row_sel;
  logic                    grp_found, col_found;
  logic                    last_exit, unlocked, grant;

  psa_ready_map #(.GRP_BITS(GRP_BITS), .COL_BITS(COL_BITS)) u_map (
    .clk_i, .rst_ni, .set_vld_i, .set_prio_i, .clr_vld_i, .clr_prio_i,
    .rows_o(rows), .group_o(group)
  );

  psa_lsb_find #(.W(N_ROWS)) u_grp_find (
    .vec_i(group), .idx_o(grp_idx), .found_o(grp_found)
  );

  assign row_sel = rows[grp_idx*ROW_W +: ROW_W];

  psa_lsb_find #(.W(ROW_W)) u_col_find (
    .vec_i(row_sel), .idx_o(col_idx), .found_o(col_found)
  );

  psa_nest_ctrl #(.NEST_W(NEST_W)) u_nest (
    .clk_i, .rst_ni, .irq_enter_i, .irq_exit_i, .lock_i, .unlock_i,
    .last_exit_o(last_exit), .unlocked_o(unlocked)
  );

  assign hi_vld_o  = grp_found && col_found;
  assign hi_prio_o = {grp_idx, col_idx};
  assign grant     = last_exit && unlocked && hi_vld_o && hi_prio_o != cur_prio_o;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cur_prio_o <= '1;
      sw_req_o   <= 1'b0;
      sw_cnt_o   <= '0;
    end else begin
      sw_req_o <= grant;
      if (grant) begin
        cur_prio_o <= hi_prio_o;
        sw_cnt_o   <= sw_cnt_o + CNT_W'(1);
      end else if (cur_load_i) begin
        cur_prio_o <= cur_prio_i;
      end
    end
  end

  AST_SW_AFTER_EXIT: assert property (@(posedge clk_i) disable iff (!rst_ni)
    sw_req_o |-> $past(irq_exit_i)); // R6
  AST_SW_UNLOCKED: assert property (@(posedge clk_i) disable iff (!rst_ni)
    sw_req_o |-> $past(unlocked)); // R7
  AST_SW_HAD_READY: assert property (@(posedge clk_i) disable iff (!rst_ni)
    sw_req_o |-> $past(hi_vld_o)); // R5
  AST_SW_CHANGES: assert property (@(posedge clk_i) disable iff (!rst_ni)
    sw_req_o |-> cur_prio_o != $past(cur_prio_o)); // R8
  AST_SW_COUNT: assert property (@(posedge clk_i) disable iff (!rst_ni)
    sw_req_o |-> sw_cnt_o == $past(sw_cnt_o) + CNT_W'(1)); // R9
  AST_GROUP_ROW: assert property (@(posedge clk_i) disable iff (!rst_ni)
    grp_found |-> col_found); // R3
endmodule

// File: tb/prio_sched_assist_tb.sv
module prio_sched_assist_tb;
  localparam int CLK_PERIOD = 10;

  logic clk = 1'b0, rst_n = 1'b0;
  logic set_vld = 0, clr_vld = 0, irq_enter = 0, irq_exit = 0;
  logic lock = 0, unlock = 0, cur_load = 0;
  logic [5:0] set_prio = 0, clr_prio = 0, cur_prio_in = 0;
  logic hi_vld, sw_req;
  logic [5:0] hi_prio, cur_prio;
  logic [31:0] sw_cnt;
  int nvec = 0, nerr = 0;
  bit done = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  prio_sched_assist u_dut (
    .clk_i(clk), .rst_ni(rst_n),
    .set_vld_i(set_vld), .set_prio_i(set_prio),
    .clr_vld_i(clr_vld), .clr_prio_i(clr_prio),
    .irq_enter_i(irq_enter), .irq_exit_i(irq_exit),
    .lock_i(lock), .unlock_i(unlock),
    .cur_load_i(cur_load), .cur_prio_i(cur_prio_in),
    .hi_vld_o(hi_vld), .hi_prio_o(hi_prio), .cur_prio_o(cur_prio),
    .sw_req_o(sw_req), .sw_cnt_o(sw_cnt)
  );

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    nvec++;
    if (act !== exp) begin
      nerr++;
      $display("FAIL %s act=%0d exp=%0d", req, act, exp);
    end
  endtask

  task automatic tick();
    @(posedge clk); #1;
    set_vld = 0; clr_vld = 0; irq_enter = 0; irq_exit = 0;
    lock = 0; unlock = 0; cur_load = 0;
  endtask

  task automatic do_set(input int p);
    set_vld = 1; set_prio = 6'(p); tick();
  endtask

  task automatic do_clr(input int p);
    clr_vld = 1; clr_prio = 6'(p); tick();
  endtask

  task automatic do_enter();
    irq_enter = 1; tick();
  endtask

  task automatic do_exit();
    irq_exit = 1; tick();
  endtask

  task automatic finish_run();
    if (!done) begin
      done = 1;
      $display("== %0d vectors applied, %0d miscompares ==", nvec, nerr);
      $finish;
    end
  endtask

  initial begin
    #(CLK_PERIOD * 150000);
    nvec++; nerr++;
    $display("FAIL watchdog act=hung exp=done");
    finish_run();
  end

  initial begin
    #(CLK_PERIOD * 3 + 1);
    rst_n = 1;
    tick();
    // R1 reset state
    chk("R1 hi_vld", hi_vld, 0);
    chk("R1 sw_req", sw_req, 0);
    chk("R1 sw_cnt", sw_cnt, 0);
    chk("R1 cur_prio", cur_prio, 63);

    // R2/R4 single task sweep, sampled in the cycle after the writing edge
    for (int p = 0; p < 64; p++) begin
      do_set(p);
      chk("R4 single vld", hi_vld, 1);
      chk("R2 single prio", hi_prio, p);
      do_clr(p);
      chk("R3 single cleared", hi_vld, 0);
    end

    // R2/R3 every ordered pair
    for (int a = 0; a < 64; a++) begin
      for (int b = 0; b < 64; b++) begin
        do_set(a);
        do_set(b);
        chk("R2 pair prio", hi_prio, (a < b) ? a : b);
        do_clr(a);
        if (a != b) begin
          chk("R3 keep other vld", hi_vld, 1);
          chk("R3 keep other prio", hi_prio, b);
        end else begin
          chk("R3 self cleared", hi_vld, 0);
        end
        do_clr(b);
        chk("R3 pair empty", hi_vld, 0);
      end
    end

    // R3 clear beats same-cycle set
    for (int p = 0; p < 64; p++) begin
      set_vld = 1; set_prio = 6'(p); clr_vld = 1; clr_prio = 6'(p); tick();
      chk("R3 clear wins", hi_vld, 0);
    end

    // R9 first switch
    do_set(10);
    do_enter();
    do_exit();
    chk("R9 sw pulse", sw_req, 1);
    chk("R9 cur loaded", cur_prio, 10);
    chk("R9 count", sw_cnt, 1);
    tick();
    chk("R9 pulse width", sw_req, 0);

    // R6 exit at zero ignored, nested exits
    do_set(5);
    do_exit();
    chk("R6 exit at zero", sw_req, 0);
    do_enter();
    do_enter();
    do_exit();
    chk("R6 inner exit", sw_req, 0);
    do_exit();
    chk("R6 last exit", sw_req, 1);
    chk("R6 cur", cur_prio, 5);
    chk("R6 count", sw_cnt, 2);
    // R6 enter and exit same cycle cancel
    do_set(2);
    do_enter();
    irq_enter = 1; irq_exit = 1; tick();
    chk("R6 cancel", sw_req, 0);
    do_exit();
    chk("R6 after cancel", sw_req, 1);
    chk("R6 cur 2", cur_prio, 2);
    do_clr(2);
    cur_load = 1; cur_prio_in = 5; tick();
    chk("R10 reload 5", cur_prio, 5);

    // R8 same priority
    do_enter();
    do_exit();
    chk("R8 no switch", sw_req, 0);
    chk("R8 count", sw_cnt, 3);

    // R7 lock saturates at zero, lock blocks
    unlock = 1; tick();
    unlock = 1; tick();
    unlock = 1; tick();
    lock = 1; tick();
    do_set(3);
    do_enter();
    do_exit();
    chk("R7 locked", sw_req, 0);
    chk("R7 locked cur", cur_prio, 5);
    unlock = 1; tick();
    do_enter();
    do_exit();
    chk("R7 unlocked", sw_req, 1);
    chk("R7 cur", cur_prio, 3);
    chk("R7 count", sw_cnt, 4);

    // R10 direct load, then switch back
    cur_load = 1; cur_prio_in = 40; tick();
    chk("R10 load", cur_prio, 40);
    chk("R10 no pulse", sw_req, 0);
    do_enter();
    do_exit();
    chk("R10 switch", sw_req, 1);
    chk("R10 cur", cur_prio, 3);
    chk("R10 count", sw_cnt, 5);

    // R5 nothing ready
    do_clr(3);
    do_clr(5);
    do_clr(10);
    chk("R5 vld", hi_vld, 0);
    cur_load = 1; cur_prio_in = 20; tick();
    do_enter();
    do_exit();
    chk("R5 no switch", sw_req, 0);
    chk("R5 count", sw_cnt, 5);
    chk("R5 cur", cur_prio, 20);

    finish_run();
  end
endmodule